// File: doc/BRIEF.md
# Clock Synthesizer Configuration Target on I2C

This block is the two-wire configuration port of a clock synthesizer. A host on an I2C bus writes and reads a small bank of byte-wide configuration registers. The block drives the working values of those registers straight out to the synthesizer logic. It also returns two read-only identification bytes and a status byte that reflects the loop-lock and phase-aligner-lock inputs.

SCL and SDA arrive as plain inputs. Both are sampled into the system clock domain. The block pulls SDA low through `sda_pull`, and an external open-drain pad turns that into a wired-AND. After the index byte, every data byte goes to the current index, and the index then steps by one, so transfers of any length walk through consecutive registers. The feedback divider and loop-control bytes form one group of double-buffered registers, and the phase-resolution byte forms a second group. A host write to either group changes only a shadow copy. The working copy, which is what the outputs carry, follows only when the host writes the right command nibble into the commit register at index 08h.

The bus side carries no stream. SCL sets the pace of every transfer and the block never holds the clock low, so the bus has no back-pressure. On the synthesizer side the outputs are static levels with no handshake.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: The block acknowledges only the 7-bit address 0100_11X, where X equals `addr_sel`; the R/W bit is the LSB of the address byte, with 1 meaning read. For any other address it leaves SDA released in the acknowledge slot and ignores the rest of the transfer.
- R2: After the address with W, the first byte sets the register index. Each following byte is written to that index, and every byte is acknowledged.
- R3: Each data byte written or read moves the index up by one, so a multi-byte transfer covers consecutive indices.
- R4: A read is an index write, then a repeated START, then the address with R. Data goes out MSB first. After the host NACKs a byte, the block releases SDA and sends nothing more.
- R5: After reset, the bytes at indices 0 to 7 read back as 41h, 00h, FFh, 0Fh, 80h, 03h, 1Fh, 80h, and the working outputs hold the same values (`cfg_fbdiv` = FFFh).
- R6: A write to index 1, 2 or 3 changes only the shadow copy, which reads back at once. `cfg_loop` and `cfg_fbdiv` (the low 4 bits of index 3 form bits 11:8 and index 2 forms bits 7:0) take the shadow values only when a byte written to index 08h has upper nibble 5h.
- R7: A write to index 5 changes only its shadow copy. `cfg_dpa` takes the shadow value only when a byte written to index 08h has lower nibble Ah. Writing 5Ah commits both groups.
- R8: Index 10h reads parameter `ID_VER` and index 11h reads `ID_REV`. Index 12h reads bit 0 = `dpa_lock` and bit 1 = `pll_lock`, with bits 7:2 at zero.
- R9: Writes to read-only or undefined indices are acknowledged and change nothing. Undefined indices read 00h. Index 08h reads 00h, and writing it changes no readable byte.
- R10: `sda_pull` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock level |
| sda_in | input | 1 | Bus data level |
| sda_pull | output | 1 | 1 pulls SDA low |
| addr_sel | input | 1 | Address bit 0 select |
| dpa_lock | input | 1 | Phase aligner locked |
| pll_lock | input | 1 | Loop locked |
| cfg_input | output | 8 | Index 0 byte |
| cfg_loop | output | 8 | Working index 1 byte |
| cfg_fbdiv | output | 12 | Working feedback divider |
| cfg_phase | output | 8 | Index 4 byte |
| cfg_dpa | output | 8 | Working index 5 byte |
| cfg_outen | output | 8 | Index 6 byte |
| cfg_oscdiv | output | 8 | Index 7 byte |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, `ID_VER` = 18h and `ID_REV` = 01h. It drives bus bits eight system clocks per quarter period. That spacing leaves the synchronizer delay well inside each SCL phase, yet keeps transfers short enough to cover both commit groups, the separate and combined commit codes, and index wrap-through. It drives `addr_sel` at both levels, so both address variants get checked, along with a mismatched address.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_IDX, ST_WR, ST_ACK, ST_TX, ST_MACK
  } i2c_st_e;

  localparam logic [5:0] DEV_BASE   = 6'b010011;
  localparam logic [7:0] IX_CMD     = 8'h08;
  localparam logic [7:0] IX_VER     = 8'h10;
  localparam logic [7:0] IX_REV     = 8'h11;
  localparam logic [7:0] IX_STAT    = 8'h12;
  localparam logic [3:0] CODE_LOOP  = 4'h5;
  localparam logic [3:0] CODE_PHASE = 4'hA;
endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkcfg_i2c_engine.sv
module clkcfg_i2c_engine
  import clkcfg_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl,
  input  logic             sda,
  input  logic             addr_sel,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  localparam int CNT_W = 4;
  localparam logic [CNT_W-1:0] BYTE_BITS = CNT_W'(8);

  i2c_st_e           state, nxt;
  logic              scl_q, sda_q, go_rd, mnack;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        sh, tx;
  logic [IDX_W-1:0]  idx;
  logic              start_evt, stop_evt, rise_evt, fall_evt;

  assign start_evt = scl & scl_q & sda_q & ~sda;
  assign stop_evt  = scl & scl_q & ~sda_q & sda;
  assign rise_evt  = scl & ~scl_q;
  assign fall_evt  = ~scl & scl_q;

  assign rd_idx  = idx;
  assign wr_idx  = idx;
  assign wr_data = sh;
  assign wr_en   = fall_evt && (state == ST_WR) && (cnt == BYTE_BITS);
  assign sda_oe  = (state == ST_ACK) || ((state == ST_TX) && !tx[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; nxt <= ST_IDLE;
      scl_q <= 1'b1; sda_q <= 1'b1;
      go_rd <= 1'b0; mnack <= 1'b1;
      cnt <= '0; sh <= '0; tx <= '0; idx <= '0;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
      if (start_evt) begin
        state <= ST_ADDR;
        cnt   <= '0;
      end else if (stop_evt) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_ADDR, ST_IDX, ST_WR: begin
            if (rise_evt) begin
              sh  <= {sh[6:0], sda};
              cnt <= cnt + 1'b1;
            end else if (fall_evt && cnt == BYTE_BITS) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (sh[7:1] == {DEV_BASE, addr_sel}) begin
                  state <= ST_ACK;
                  go_rd <= sh[0];
                  nxt   <= ST_IDX;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                if (state == ST_IDX) idx <= sh[IDX_W-1:0];
                else                 idx <= idx + 1'b1;
                state <= ST_ACK;
                go_rd <= 1'b0;
                nxt   <= ST_WR;
              end
            end
          end
          ST_ACK: begin
            if (fall_evt) begin
              cnt <= '0;
              if (go_rd) begin
                tx    <= rd_data;
                idx   <= idx + 1'b1;
                state <= ST_TX;
              end else begin
                state <= nxt;
              end
            end
          end
          ST_TX: begin
            if (rise_evt) cnt <= cnt + 1'b1;
            else if (fall_evt) begin
              if (cnt == BYTE_BITS) begin
                state <= ST_MACK;
                cnt   <= '0;
              end else begin
                tx <= {tx[6:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (rise_evt) mnack <= sda;
            else if (fall_evt) begin
              if (mnack) state <= ST_IDLE;
              else begin
                tx    <= rd_data;
                idx   <= idx + 1'b1;
                state <= ST_TX;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && scl_q) |=> (!scl || $stable(sda_oe)));

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int         IDX_W  = 8,
  parameter logic [7:0] ID_VER = 8'h18,
  parameter logic [7:0] ID_REV = 8'h01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             dpa_lock,
  input  logic             pll_lock,
  output logic [7:0]       rd_data,
  output logic [7:0]       cfg_input,
  output logic [7:0]       cfg_loop,
  output logic [11:0]      cfg_fbdiv,
  output logic [7:0]       cfg_phase,
  output logic [7:0]       cfg_dpa,
  output logic [7:0]       cfg_outen,
  output logic [7:0]       cfg_oscdiv
);
  logic [7:0] r_in, r_ph, r_oe, r_osc, s_loop, s_fbl, s_dpa;
  logic [3:0] s_fbh;
  logic       cmd_wr;

  assign cmd_wr = wr_en && (wr_idx == IDX_W'(IX_CMD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_in <= 8'h41; s_loop <= 8'h00; s_fbl <= 8'hFF; s_fbh <= 4'hF;
      r_ph <= 8'h80; s_dpa  <= 8'h03; r_oe  <= 8'h1F; r_osc <= 8'h80;
      cfg_loop <= 8'h00; cfg_fbdiv <= 12'hFFF; cfg_dpa <= 8'h03;
    end else if (wr_en) begin
      case (wr_idx)
        IDX_W'(0): r_in   <= wr_data;
        IDX_W'(1): s_loop <= wr_data;
        IDX_W'(2): s_fbl  <= wr_data;
        IDX_W'(3): s_fbh  <= wr_data[3:0];
        IDX_W'(4): r_ph   <= wr_data;
        IDX_W'(5): s_dpa  <= wr_data;
        IDX_W'(6): r_oe   <= wr_data;
        IDX_W'(7): r_osc  <= wr_data;
        default: ;
      endcase
      if (cmd_wr && wr_data[7:4] == CODE_LOOP) begin
        cfg_loop  <= s_loop;
        cfg_fbdiv <= {s_fbh, s_fbl};
      end
      if (cmd_wr && wr_data[3:0] == CODE_PHASE) cfg_dpa <= s_dpa;
    end
  end

  always_comb begin
    case (rd_idx)
      IDX_W'(0):       rd_data = r_in;
      IDX_W'(1):       rd_data = s_loop;
      IDX_W'(2):       rd_data = s_fbl;
      IDX_W'(3):       rd_data = {4'h0, s_fbh};
      IDX_W'(4):       rd_data = r_ph;
      IDX_W'(5):       rd_data = s_dpa;
      IDX_W'(6):       rd_data = r_oe;
      IDX_W'(7):       rd_data = r_osc;
      IDX_W'(IX_VER):  rd_data = ID_VER;
      IDX_W'(IX_REV):  rd_data = ID_REV;
      IDX_W'(IX_STAT): rd_data = {6'b0, pll_lock, dpa_lock};
      default:         rd_data = 8'h00;
    endcase
  end

  assign cfg_input  = r_in;
  assign cfg_phase  = r_ph;
  assign cfg_outen  = r_oe;
  assign cfg_oscdiv = r_osc;

  // R6
  loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && wr_data[7:4] == CODE_LOOP) |=> ($stable(cfg_fbdiv) && $stable(cfg_loop)));

  // R7
  dpa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_wr && wr_data[3:0] == CODE_PHASE) |=> $stable(cfg_dpa));

  // R9
  cmd_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> $stable({r_in, s_loop, s_fbl, s_fbh, r_ph, s_dpa, r_oe, r_osc}));
endmodule

// File: rtl/clkcfg_i2c_target.sv
module clkcfg_i2c_target #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] ID_VER      = 8'h18,
  parameter logic [7:0] ID_REV      = 8'h01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        sda_pull,
  input  logic        addr_sel,
  input  logic        dpa_lock,
  input  logic        pll_lock,
  output logic [7:0]  cfg_input,
  output logic [7:0]  cfg_loop,
  output logic [11:0] cfg_fbdiv,
  output logic [7:0]  cfg_phase,
  output logic [7:0]  cfg_dpa,
  output logic [7:0]  cfg_outen,
  output logic [7:0]  cfg_oscdiv
);
  localparam int IDX_W = 8;

  logic             scl_s, sda_s, wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;

  clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
  clkcfg_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  clkcfg_i2c_engine #(.IDX_W(IDX_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl(scl_s), .sda(sda_s), .addr_sel(addr_sel),
    .rd_data(rd_data), .rd_idx(rd_idx), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .sda_oe(sda_pull));

  clkcfg_regbank #(.IDX_W(IDX_W), .ID_VER(ID_VER), .ID_REV(ID_REV)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .dpa_lock(dpa_lock), .pll_lock(pll_lock), .rd_data(rd_data),
    .cfg_input(cfg_input), .cfg_loop(cfg_loop), .cfg_fbdiv(cfg_fbdiv),
    .cfg_phase(cfg_phase), .cfg_dpa(cfg_dpa), .cfg_outen(cfg_outen),
    .cfg_oscdiv(cfg_oscdiv));
endmodule

// File: tb/clkcfg_i2c_target_tb_top.sv
module clkcfg_i2c_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic addr_sel = 1'b0, dpa_lock = 1'b0, pll_lock = 1'b0;
  logic sda_pull;
  logic [7:0] cfg_input, cfg_loop, cfg_phase, cfg_dpa, cfg_outen, cfg_oscdiv;
  logic [11:0] cfg_fbdiv;
  wire sda_line = m_sda & ~sda_pull;

  int checks = 0, errors = 0, r10_viol = 0;
  logic tgt_x = 1'b0, all_ack, bus_ack;
  logic [7:0] wbuf [0:7];
  logic [7:0] rbuf [0:7];
  logic prev_scl = 1'b1, prev_pull = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkcfg_i2c_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line), .sda_pull(sda_pull),
    .addr_sel(addr_sel), .dpa_lock(dpa_lock), .pll_lock(pll_lock),
    .cfg_input(cfg_input), .cfg_loop(cfg_loop), .cfg_fbdiv(cfg_fbdiv),
    .cfg_phase(cfg_phase), .cfg_dpa(cfg_dpa), .cfg_outen(cfg_outen),
    .cfg_oscdiv(cfg_oscdiv));

  // R10 monitor: pull must not move while the bus clock stays high
  always @(negedge clk) begin
    if (rst_n && m_scl && prev_scl && sda_pull !== prev_pull) r10_viol++;
    prev_scl  <= m_scl;
    prev_pull <= sda_pull;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qwait;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; qwait; m_scl = 1'b1; qwait;
    m_sda = 1'b0; qwait; m_scl = 1'b0; qwait;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; qwait; m_scl = 1'b1; qwait; m_sda = 1'b1; qwait;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qwait; m_scl = 1'b1; qwait; qwait; m_scl = 1'b0; qwait;
    end
    m_sda = 1'b1; qwait; m_scl = 1'b1; qwait;
    ack = ~sda_line;
    qwait; m_scl = 1'b0; qwait;
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait; m_scl = 1'b1; qwait; b[i] = sda_line; qwait; m_scl = 1'b0; qwait;
    end
    m_sda = nack; qwait; m_scl = 1'b1; qwait; qwait; m_scl = 1'b0; qwait;
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {6'b010011, tgt_x, rd};
  endfunction

  task automatic write_seq(input logic [7:0] idx, input int n);
    all_ack = 1'b1;
    bus_start;
    send_byte(dev(1'b0), bus_ack); all_ack &= bus_ack;
    send_byte(idx, bus_ack);       all_ack &= bus_ack;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], bus_ack); all_ack &= bus_ack;
    end
    bus_stop;
  endtask

  task automatic read_seq(input logic [7:0] idx, input int n);
    all_ack = 1'b1;
    bus_start;
    send_byte(dev(1'b0), bus_ack); all_ack &= bus_ack;
    send_byte(idx, bus_ack);       all_ack &= bus_ack;
    bus_start;
    send_byte(dev(1'b1), bus_ack); all_ack &= bus_ack;
    for (int k = 0; k < n; k++) recv_byte(k == n - 1, rbuf[k]);
    qwait;
    chk("R4 line released after NACK", sda_pull, 1'b0);
    bus_stop;
  endtask

  task automatic t_reset;
    chk("R5 cfg_input", cfg_input, 8'h41);
    chk("R5 cfg_loop", cfg_loop, 8'h00);
    chk("R5 cfg_fbdiv", cfg_fbdiv, 12'hFFF);
    chk("R5 cfg_phase", cfg_phase, 8'h80);
    chk("R5 cfg_dpa", cfg_dpa, 8'h03);
    chk("R5 cfg_outen", cfg_outen, 8'h1F);
    chk("R5 cfg_oscdiv", cfg_oscdiv, 8'h80);
    read_seq(8'h00, 8);
    chk("R4 read acks", all_ack, 1'b1);
    chk("R3 R5 rd0", rbuf[0], 8'h41); chk("R3 R5 rd1", rbuf[1], 8'h00);
    chk("R3 R5 rd2", rbuf[2], 8'hFF); chk("R3 R5 rd3", rbuf[3], 8'h0F);
    chk("R3 R5 rd4", rbuf[4], 8'h80); chk("R3 R5 rd5", rbuf[5], 8'h03);
    chk("R3 R5 rd6", rbuf[6], 8'h1F); chk("R3 R5 rd7", rbuf[7], 8'h80);
  endtask

  task automatic t_address;
    logic a;
    addr_sel = 1'b0; tgt_x = 1'b1;
    bus_start; send_byte(dev(1'b0), a); bus_stop;
    chk("R1 mismatched address not acked", a, 1'b0);
    addr_sel = 1'b1;
    wbuf[0] = 8'h9C; write_seq(8'h04, 1);
    chk("R1 high-select address acked", all_ack, 1'b1);
    chk("R1 R2 cfg_phase written", cfg_phase, 8'h9C);
    addr_sel = 1'b0; tgt_x = 1'b0;
    wbuf[0] = 8'h77;
    tgt_x = 1'b1; write_seq(8'h04, 1); tgt_x = 1'b0;
    chk("R1 ignored transfer leaves cfg_phase", cfg_phase, 8'h9C);
  endtask

  task automatic t_random;
    wbuf[0] = 8'hA5; write_seq(8'h00, 1);
    chk("R2 write acks", all_ack, 1'b1);
    chk("R2 cfg_input", cfg_input, 8'hA5);
    read_seq(8'h00, 1);
    chk("R4 readback MSB first", rbuf[0], 8'hA5);
  endtask

  task automatic t_sequential;
    wbuf[0] = 8'h12; wbuf[1] = 8'h34; write_seq(8'h06, 2);
    chk("R3 cfg_outen", cfg_outen, 8'h12);
    chk("R3 cfg_oscdiv", cfg_oscdiv, 8'h34);
    read_seq(8'h06, 2);
    chk("R3 seq rd6", rbuf[0], 8'h12);
    chk("R3 seq rd7", rbuf[1], 8'h34);
  endtask

  task automatic t_shadow;
    wbuf[0] = 8'h21; wbuf[1] = 8'h34; wbuf[2] = 8'hAB; write_seq(8'h01, 3);
    wbuf[0] = 8'h02; write_seq(8'h05, 1);
    chk("R6 loop held", cfg_loop, 8'h00);
    chk("R6 fbdiv held", cfg_fbdiv, 12'hFFF);
    chk("R7 dpa held", cfg_dpa, 8'h03);
    read_seq(8'h01, 3);
    chk("R6 shadow rd1", rbuf[0], 8'h21);
    chk("R6 shadow rd2", rbuf[1], 8'h34);
    chk("R6 shadow rd3", rbuf[2], 8'h0B);
    wbuf[0] = 8'h50; write_seq(8'h08, 1);
    chk("R6 loop commit", cfg_loop, 8'h21);
    chk("R6 fbdiv commit", cfg_fbdiv, 12'hB34);
    chk("R7 dpa not committed by 50h", cfg_dpa, 8'h03);
    wbuf[0] = 8'h4A; wbuf[1] = 8'h0A; write_seq(8'h01, 1);
    wbuf[0] = 8'h0A; write_seq(8'h08, 1);
    chk("R7 dpa commit", cfg_dpa, 8'h02);
    chk("R6 loop not committed by 0Ah", cfg_loop, 8'h21);
    wbuf[0] = 8'h01; write_seq(8'h05, 1);
    wbuf[0] = 8'h5A; write_seq(8'h08, 1);
    chk("R6 both commit loop", cfg_loop, 8'h4A);
    chk("R7 both commit dpa", cfg_dpa, 8'h01);
    read_seq(8'h08, 1);
    chk("R9 cmd index reads zero", rbuf[0], 8'h00);
    read_seq(8'h00, 8);
    chk("R9 cmd write left rd0", rbuf[0], 8'hA5);
    chk("R9 cmd write left rd1", rbuf[1], 8'h4A);
    chk("R9 cmd write left rd5", rbuf[5], 8'h01);
  endtask

  task automatic t_readonly;
    dpa_lock = 1'b1; pll_lock = 1'b0;
    wbuf[0] = 8'h00; wbuf[1] = 8'h00; wbuf[2] = 8'hFF; write_seq(8'h10, 3);
    chk("R9 read-only writes acked", all_ack, 1'b1);
    read_seq(8'h10, 3);
    chk("R8 version", rbuf[0], 8'h18);
    chk("R8 revision", rbuf[1], 8'h01);
    chk("R8 status dpa only", rbuf[2], 8'h01);
    dpa_lock = 1'b0; pll_lock = 1'b1;
    read_seq(8'h12, 1);
    chk("R8 status pll only", rbuf[0], 8'h02);
    wbuf[0] = 8'hEE; write_seq(8'h20, 1);
    chk("R9 undefined write acked", all_ack, 1'b1);
    read_seq(8'h20, 1);
    chk("R9 undefined reads zero", rbuf[0], 8'h00);
    wbuf[0] = 8'h66; write_seq(8'h09, 1);
    chk("R9 outputs unchanged input", cfg_input, 8'hA5);
    chk("R9 outputs unchanged outen", cfg_outen, 8'h12);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_address;
    t_random;
    t_sequential;
    t_shadow;
    t_readonly;
    chk("R10 pull stable while SCL high", r10_viol, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule